// File: doc/BRIEF.md
# UART Text and Hex Printer

This block produces console output for a byte-wide UART transmitter. A command is started by a one-cycle `start` pulse with `cmd_hex` choosing the kind of output. In text mode the block reads a zero-terminated byte string through a small read port, beginning at `base_addr`. Every line feed in the string goes out as a carriage return followed by the line feed. In hex mode the block takes the 32-bit `hex_word` and sends it as eight uppercase ASCII hex digits, the most significant nibble first.

Before every byte it sends, the block waits until the transmitter reports its holding register empty (`thr_empty`). It then writes the byte with a one-cycle `tx_wr` strobe. `busy` is high for the whole command, and `done` pulses once at its end. The serializer, the baud generator and the string storage sit outside the block.

The controller is one state machine. Its states are ST_IDLE, ST_STR_LOAD (fetch a string byte), ST_HEX_LOAD (take the next nibble), ST_WAIT_EMPTY (hold the byte until `thr_empty`), ST_GAP (one cycle after each write) and ST_DONE (the done pulse). Its transitions are as follows:
- start: ST_IDLE goes to ST_STR_LOAD or ST_HEX_LOAD.
- terminator: ST_STR_LOAD goes to ST_DONE.
- byte ready: ST_STR_LOAD or ST_HEX_LOAD goes to ST_WAIT_EMPTY.
- write: ST_WAIT_EMPTY goes to ST_GAP.
- pending line feed: ST_GAP goes back to ST_WAIT_EMPTY.
- next byte: ST_GAP goes to ST_STR_LOAD or ST_HEX_LOAD.
- digits drained: ST_GAP goes to ST_DONE.
- finish: ST_DONE goes to ST_IDLE.

Top module: `tx_text_printer`

## Requirements
- R1: `tx_wr` is asserted only in a cycle where `thr_empty` is high.
- R2: Each byte write is a single-cycle `tx_wr` strobe. Two writes never fall in consecutive cycles.
- R3: In text mode (`cmd_hex`=0), a string byte 0x0A is sent as two writes: 0x0D first, then 0x0A.
- R4: In text mode, a string byte 0x00 ends the command and is never sent. Every other byte, including 0x0D and 0xFF, is sent unchanged and in rising address order.
- R5: In hex mode (`cmd_hex`=1), exactly eight characters are sent. The first encodes `hex_word[31:28]` and the last encodes `hex_word[3:0]`.
- R6: A nibble value n from 0 to 9 is sent as 0x30+n.
- R7: A nibble value n from 10 to 15 is sent as 0x41+(n-10), which is an uppercase letter.
- R8: Each accepted text command restarts the read address at `base_addr`. `mem_addr` equals `base_addr` in the cycle after `start`, and it rises by one per byte fetched.
- R9: `done` is high for exactly one cycle. In hex mode it follows the last write; in text mode it follows the fetch of the terminator. `busy` falls in the cycle after `done`.
- R10: A `start` pulse while `busy` is high is ignored. It causes no extra write, no extra `done`, and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command request |
| cmd_hex | input | 1 | Command select: 0 text string, 1 hex word |
| base_addr | input | ADDR_W | First string address for a text command |
| hex_word | input | WORD_W | Value to print for a hex command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| mem_rd | output | 1 | String read strobe |
| mem_addr | output | ADDR_W | String read address; data is expected in the same cycle |
| mem_data | input | 8 | String byte at `mem_addr` |
| thr_empty | input | 1 | Transmitter holding register empty |
| tx_wr | output | 1 | Byte write strobe to the transmitter |
| tx_data | output | 8 | Byte written with `tx_wr` |

## Verification
A wrong state or a wrong pending line-feed flag shows up at the next `tx_wr`. There the byte is wrong, missing or extra, so the error appears within one transmit slot of the fault. A bad nibble shifter or counter shows as a digit out of order, or as `done` arriving early or late against the eight expected characters. A pointer that does not restart shows in `mem_addr` one cycle after `start`, and as a wrong string on the very first byte.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_STR_LOAD   = 3'd1,
        ST_HEX_LOAD   = 3'd2,
        ST_WAIT_EMPTY = 3'd3,
        ST_GAP        = 3'd4,
        ST_DONE       = 3'd5
    } ptx_state_t;

    typedef enum logic {
        MODE_TEXT = 1'b0,
        MODE_HEX  = 1'b1
    } ptx_mode_t;

    localparam logic [7:0] CHAR_NUL = 8'h00;
    localparam logic [7:0] CHAR_LF  = 8'h0A;
    localparam logic [7:0] CHAR_CR  = 8'h0D;

endpackage

// File: rtl/ptx_nibble_ascii.sv
module ptx_nibble_ascii (
    input  logic [3:0] nib,
    output logic [7:0] ascii
);
    localparam logic [7:0] DIGIT_BASE  = 8'h30;
    localparam logic [7:0] LETTER_BASE = 8'h41 - 8'd10;

    always_comb begin
        if (nib < 4'd10) begin
            ascii = DIGIT_BASE + {4'h0, nib};
        end else begin
            ascii = LETTER_BASE + {4'h0, nib};
        end
    end
endmodule

// File: rtl/ptx_word_shifter.sv
module ptx_word_shifter #(
    parameter int WORD_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] value,
    input  logic              shift,
    output logic [NIB_W-1:0]  top_nib,
    output logic              drained
);
    localparam int DIGITS = WORD_W / NIB_W;
    localparam int CW     = $clog2(DIGITS + 1);

    logic [WORD_W-1:0] word_q;
    logic [CW-1:0]     left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= value;
            left_q <= CW'(DIGITS);
        end else if (shift && left_q != '0) begin
            word_q <= word_q << NIB_W;
            left_q <= left_q - 1'b1;
        end
    end

    assign top_nib = word_q[WORD_W-1 -: NIB_W];
    assign drained = (left_q == '0);
endmodule

// File: rtl/ptx_str_ptr.sv
module ptx_str_ptr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              incr,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (incr) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/tx_text_printer.sv
module tx_text_printer #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_hex,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [WORD_W-1:0] hex_word,
    output logic              busy,
    output logic              done,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_data,
    input  logic              thr_empty,
    output logic              tx_wr,
    output logic [7:0]        tx_data
);
    import ptx_pkg::*;

    localparam int NIB_W = 4;

    ptx_state_t state_q, state_d;
    ptx_mode_t  mode_q, mode_d;
    logic [7:0] cur_q, cur_d;
    logic       pend_lf_q, pend_lf_d;

    logic             ptr_load, ptr_incr;
    logic             sh_load, sh_shift;
    logic [NIB_W-1:0] top_nib;
    logic             sh_drained;
    logic [7:0]       nib_char;

    ptx_str_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ptr_load),
        .base  (base_addr),
        .incr  (ptr_incr),
        .addr  (mem_addr)
    );

    ptx_word_shifter #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .value   (hex_word),
        .shift   (sh_shift),
        .top_nib (top_nib),
        .drained (sh_drained)
    );

    ptx_nibble_ascii u_nib (
        .nib   (top_nib),
        .ascii (nib_char)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_TEXT;
            cur_q     <= CHAR_NUL;
            pend_lf_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            mode_q    <= mode_d;
            cur_q     <= cur_d;
            pend_lf_q <= pend_lf_d;
        end
    end

    // Next state and control
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        cur_d     = cur_q;
        pend_lf_d = pend_lf_q;
        ptr_load  = 1'b0;
        ptr_incr  = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    pend_lf_d = 1'b0;
                    if (cmd_hex) begin
                        mode_d  = MODE_HEX;
                        sh_load = 1'b1;
                        state_d = ST_HEX_LOAD;
                    end else begin
                        mode_d   = MODE_TEXT;
                        ptr_load = 1'b1;
                        state_d  = ST_STR_LOAD;
                    end
                end
            end
            ST_STR_LOAD: begin
                ptr_incr = 1'b1;
                if (mem_data == CHAR_NUL) begin
                    state_d = ST_DONE;
                end else if (mem_data == CHAR_LF) begin
                    cur_d     = CHAR_CR;
                    pend_lf_d = 1'b1;
                    state_d   = ST_WAIT_EMPTY;
                end else begin
                    cur_d     = mem_data;
                    pend_lf_d = 1'b0;
                    state_d   = ST_WAIT_EMPTY;
                end
            end
            ST_HEX_LOAD: begin
                cur_d     = nib_char;
                pend_lf_d = 1'b0;
                sh_shift  = 1'b1;
                state_d   = ST_WAIT_EMPTY;
            end
            ST_WAIT_EMPTY: begin
                if (thr_empty) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (pend_lf_q) begin
                    cur_d     = CHAR_LF;
                    pend_lf_d = 1'b0;
                    state_d   = ST_WAIT_EMPTY;
                end else if (mode_q == MODE_TEXT) begin
                    state_d = ST_STR_LOAD;
                end else if (sh_drained) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_HEX_LOAD;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        mem_rd  = (state_q == ST_STR_LOAD);
        tx_wr   = (state_q == ST_WAIT_EMPTY) && thr_empty;
        tx_data = cur_q;
    end

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cmd_hex,
    input logic [ADDR_W-1:0] base_addr,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              thr_empty,
    input logic              tx_wr,
    input logic [7:0]        tx_data,
    input logic              hex_mode
);
    assert_wr_needs_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> thr_empty);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_wr);

    assert_no_nul_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !hex_mode) |-> (tx_data != 8'h00));

    assert_hex_charset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && hex_mode) |-> ((tx_data >= 8'h30 && tx_data <= 8'h39) ||
                                 (tx_data >= 8'h41 && tx_data <= 8'h46)));  // R7 as well

    assert_ptr_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cmd_hex) |=> (mem_addr == $past(base_addr)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_wr);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(hex_mode));
endmodule

bind tx_text_printer ptx_checker #(.ADDR_W(ADDR_W)) u_ptx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_hex   (cmd_hex),
    .base_addr (base_addr),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .thr_empty (thr_empty),
    .tx_wr     (tx_wr),
    .tx_data   (tx_data),
    .hex_mode  (mode_q)
);

// File: tb/test_tx_text_printer.sv
`timescale 1ns/1ps
module test_tx_text_printer;
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cmd_hex = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic [WORD_W-1:0] hex_word = '0;
    logic              busy, done, mem_rd, tx_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_data, tx_data;
    logic              thr_empty;

    logic [7:0] mem [0:255];
    logic [7:0] expq[$];
    string      tagq[$];
    int         tests = 0;
    int         fails = 0;
    int         dones = 0;
    int         cyc = 0;
    int         gap_cfg = 0;
    int         dly = 0;
    logic       prev_wr = 1'b0;
    logic       prev_done = 1'b0;

    always #10 clk = ~clk;

    assign mem_data = mem[mem_addr];

    tx_text_printer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_tx_text_printer (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_hex(cmd_hex),
        .base_addr(base_addr), .hex_word(hex_word), .busy(busy), .done(done),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .thr_empty(thr_empty), .tx_wr(tx_wr), .tx_data(tx_data)
    );

    // Behavioural transmitter: holding register busy after each write
    always @(posedge clk) begin
        if (!rst_n) begin
            thr_empty <= 1'b1;
            dly <= 0;
        end else if (tx_wr) begin
            thr_empty <= 1'b0;
            dly <= gap_cfg;
        end else if (!thr_empty) begin
            if (dly == 0) thr_empty <= 1'b1;
            else dly <= dly - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_wr) begin
                check(thr_empty, "R1", thr_empty, 1);
                check(!prev_wr, "R2", prev_wr, 0);
                if (expq.size() == 0) begin
                    check(1'b0, "R10 unexpected write", tx_data, 0);
                end else begin
                    automatic logic [7:0] e = expq.pop_front();
                    automatic string t = tagq.pop_front();
                    check(tx_data == e, t, tx_data, e);
                end
            end
            if (done) begin
                dones++;
                check(expq.size() == 0, "R9 done before last char", expq.size(), 0);
                check(!prev_done, "R9 done width", prev_done, 0);
            end
            prev_wr = tx_wr;
            prev_done = done;
        end
    end

    task automatic expect_string(input int base);
        automatic int a = base;
        while (mem[a[7:0]] != 8'h00) begin
            if (mem[a[7:0]] == 8'h0A) begin
                expq.push_back(8'h0D); tagq.push_back("R3 CR");
                expq.push_back(8'h0A); tagq.push_back("R3 LF");
            end else begin
                expq.push_back(mem[a[7:0]]); tagq.push_back("R4 byte");
            end
            a++;
        end
    endtask

    task automatic expect_hex(input logic [31:0] v);
        for (int i = 7; i >= 0; i--) begin
            automatic int n = (v >> (4 * i)) & 32'hF;
            if (n < 10) begin
                expq.push_back(8'(8'h30 + n)); tagq.push_back("R5 R6 digit");
            end else begin
                expq.push_back(8'(8'h41 + n - 10)); tagq.push_back("R5 R7 letter");
            end
        end
    endtask

    task automatic run_cmd(input bit hx, input logic [7:0] base, input logic [31:0] v,
                           input bit poke_busy);
        automatic int d0 = dones;
        if (hx) expect_hex(v); else expect_string(base);
        @(negedge clk);
        start = 1'b1; cmd_hex = hx; base_addr = base; hex_word = v;
        @(negedge clk);
        start = 1'b0;
        if (!hx) check(mem_addr == base, "R8 restart", mem_addr, base);
        check(busy, "R9 busy", busy, 1);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start = 1'b1; cmd_hex = ~hx; base_addr = 8'h10; hex_word = 32'hDEAD_BEEF;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones == d0) @(negedge clk);
        @(negedge clk);
        check(!busy, "R9 busy after done", busy, 0);
        repeat (12) @(negedge clk);
        check(dones == d0 + 1, "R10 single done", dones - d0, 1);
        check(expq.size() == 0, "R4 R5 stream length", expq.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[8'h10] = 8'h41; mem[8'h11] = 8'h0A; mem[8'h12] = 8'h62; mem[8'h13] = 8'h00;
        mem[8'h30] = 8'h0A; mem[8'h31] = 8'h0A; mem[8'h32] = 8'h7E;
        mem[8'h33] = 8'hFF; mem[8'h34] = 8'h0D; mem[8'h35] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy && !done && !tx_wr, "reset", {busy, done, tx_wr}, 0);
        rst_n = 1'b1;
        run_cmd(1'b0, 8'h10, 32'h0, 1'b0);
        run_cmd(1'b0, 8'h20, 32'h0, 1'b0);
        gap_cfg = 3;
        run_cmd(1'b0, 8'h30, 32'h0, 1'b0);
        run_cmd(1'b1, 8'h00, 32'h0123_4567, 1'b0);
        gap_cfg = 0;
        run_cmd(1'b1, 8'h00, 32'h89AB_CDEF, 1'b0);
        run_cmd(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b1);
        run_cmd(1'b1, 8'h00, 32'h0000_0000, 1'b0);
        gap_cfg = 2;
        run_cmd(1'b0, 8'h30, 32'h0, 1'b1);
        run_cmd(1'b0, 8'h10, 32'h0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule